// File: doc/BRIEF.md
# Link error status and interrupt register bank

This block is the byte-wide register bank that a host uses to watch and steer the links of a 16-port serial crosspoint switch. Each link reports errors of four classes as single-cycle pulses: cell-clock, data recovery, threshold and link. The bank latches each pulse into a per-class, per-link sticky bit. Reading an error byte returns its bits and clears them. An error that arrives in the same cycle as that read is kept.

The four error classes are combined into one active-low interrupt. Each class has its own interrupt mask bit. Each class also has its own enable for automatic relinking. When an enabled class goes from empty to non-empty, the bank sends a one-cycle reinitialization pulse to the links flagged in that class. The host can also send this pulse to any link directly, through a self-clearing resync write. The bank also holds the per-link output-disable and loopback controls, a 4-bit cell clock delay and a self-test enable bit.

The host interface has a 6-bit address, 8-bit write and read data, and write and read strobes. Read data is registered: it appears in the cycle after the read strobe and is zero in every other cycle.

Top module: `xbar_err_regs`

## Requirements
- R1: A pulse on a link's bit of `ev_cell`, `ev_recov`, `ev_thresh` or `ev_link` sets that link's bit in the matching error register. The registers are read at these addresses: cell-clock at 0x00 (links 7..0) and 0x01 (links 15..8), data recovery at 0x02/0x03, threshold at 0x04/0x05, link at 0x06/0x07.
- R2: Reading an error byte returns its bits and clears only that byte. The other byte of the same register keeps its contents.
- R3: An event that arrives in the same cycle as a read that clears its byte remains set after the read.
- R4: Address 0x09 bits 3..0 are the interrupt enables: bit 3 for cell-clock, bit 2 for data recovery, bit 1 for threshold, bit 0 for link. `irq_n` is low exactly while at least one enabled class has a non-zero error register.
- R5: Address 0x08 is read-only. Its bits 3..0 show which error registers are non-zero, using the same bit order as R4, whether or not the enables are set.
- R6: Address 0x09 bits 7..4 are the relink enables: bit 7 for cell-clock, bit 6 for data recovery, bit 5 for threshold, bit 4 for link. When an enabled class's register goes from zero to non-zero, `reinit` pulses for one cycle, one cycle after the capturing edge, on the links set in that register. Further errors in a class that is already non-zero cause no new pulse.
- R7: Writing to 0x0B (links 7..0) or 0x0C (links 15..8) pulses `reinit` for one cycle, in the cycle after the write, on every link whose written bit is 1. These addresses read as zero.
- R8: Addresses 0x0D/0x0E hold the output-disable bits and drive `out_en` inverted. Addresses 0x0F/0x10 drive `loopback`. All four read back as written.
- R9: Address 0x0A bits 3..0 drive `cell_delay` and bit 4 drives `bist_en`. Its bits 7..5 read as zero.
- R10: `rd_data` is zero in any cycle that does not follow a read, and after reads of 0x11..0x3F. Writes to 0x00..0x08 have no effect.
- R11: Reset clears every register. After reset `irq_n` is high, `reinit` and `loopback` are zero and `out_en` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (clears error bytes) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| ev_cell | input | 16 | Per-link cell-clock error pulses |
| ev_recov | input | 16 | Per-link data recovery error pulses |
| ev_thresh | input | 16 | Per-link threshold error pulses |
| ev_link | input | 16 | Per-link link error pulses |
| irq_n | output | 1 | Summary interrupt, active low |
| reinit | output | 16 | Per-link reinitialization pulse |
| out_en | output | 16 | Per-link serial output enable |
| loopback | output | 16 | Per-link loopback select |
| cell_delay | output | 4 | Cell clock delay setting |
| bist_en | output | 1 | Self-test enable |

## Verification
The bench builds the bank with its default parameters: 16 links, a 6-bit address and 8-bit data. With these values both bytes of every per-link register carry live bits. This lets the bench show that a clearing read of one byte leaves the other byte alone, and that a resync write to the upper byte reaches links 15..8. It also brings the boundary between the last mapped address 0x10 and the unmapped range into reach.

// File: rtl/xbar_err_regs.sv
module xbar_err_regs #(
  parameter int NLINK = 16,
  parameter int AW    = 6,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic [NLINK-1:0] ev_cell,
  input  logic [NLINK-1:0] ev_recov,
  input  logic [NLINK-1:0] ev_thresh,
  input  logic [NLINK-1:0] ev_link,
  output logic             irq_n,
  output logic [NLINK-1:0] reinit,
  output logic [NLINK-1:0] out_en,
  output logic [NLINK-1:0] loopback,
  output logic [3:0]       cell_delay,
  output logic             bist_en
);
  localparam int NCLS = 4;
  localparam int PW   = 2 * DW;
  localparam logic [PW-1:0] LMASK = PW'((64'd1 << NLINK) - 64'd1);
  localparam logic [AW-1:0] A_STAT = AW'(8);
  localparam logic [AW-1:0] A_CTL  = AW'(9);
  localparam logic [AW-1:0] A_MISC = AW'(10);
  localparam logic [AW-1:0] A_RSY  = AW'(11);
  localparam logic [AW-1:0] A_ODIS = AW'(13);
  localparam logic [AW-1:0] A_LPBK = AW'(15);

  logic [PW-1:0]   err_q [NCLS];
  logic [PW-1:0]   ev    [NCLS];
  logic [PW-1:0]   clr   [NCLS];
  logic [PW-1:0]   odis_q, lpbk_q, reinit_q, rsy_mask, auto_mask;
  logic [DW-1:0]   ctl_q, rd_mux;
  logic [4:0]      misc_q;
  logic [NCLS-1:0] sum, en_sum, arm_q, rise;

  assign ev[0] = PW'(ev_cell);
  assign ev[1] = PW'(ev_recov);
  assign ev[2] = PW'(ev_thresh);
  assign ev[3] = PW'(ev_link);

  // class c reports on status bit NCLS-1-c
  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      sum[NCLS-1-c] = |err_q[c];
      clr[c] = '0;
      if (rd_en && addr == AW'(2*c))   clr[c] = {{DW{1'b0}}, {DW{1'b1}}};
      if (rd_en && addr == AW'(2*c+1)) clr[c] = {{DW{1'b1}}, {DW{1'b0}}};
    end
  end

  assign en_sum = sum & ctl_q[7:4];
  assign rise   = en_sum & ~arm_q;
  assign irq_n  = ~|(sum & ctl_q[3:0]);

  always_comb begin
    auto_mask = '0;
    for (int c = 0; c < NCLS; c++)
      if (rise[NCLS-1-c]) auto_mask = auto_mask | err_q[c];
  end

  assign rsy_mask = !wr_en                  ? '0 :
                    (addr == A_RSY)         ? PW'(wr_data) :
                    (addr == A_RSY + AW'(1)) ? {wr_data, {DW{1'b0}}} : '0;

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCLS; c++) begin
      if (addr == AW'(2*c))   rd_mux = err_q[c][DW-1:0];
      if (addr == AW'(2*c+1)) rd_mux = err_q[c][PW-1:DW];
    end
    if (addr == A_STAT)            rd_mux = DW'(sum);
    if (addr == A_CTL)             rd_mux = ctl_q;
    if (addr == A_MISC)            rd_mux = DW'(misc_q);
    if (addr == A_ODIS)            rd_mux = odis_q[DW-1:0];
    if (addr == A_ODIS + AW'(1))   rd_mux = odis_q[PW-1:DW];
    if (addr == A_LPBK)            rd_mux = lpbk_q[DW-1:0];
    if (addr == A_LPBK + AW'(1))   rd_mux = lpbk_q[PW-1:DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCLS; c++) err_q[c] <= '0;
      arm_q    <= '0;
      reinit_q <= '0;
      rd_data  <= '0;
      ctl_q    <= '0;
      misc_q   <= '0;
      odis_q   <= '0;
      lpbk_q   <= '0;
    end else begin
      for (int c = 0; c < NCLS; c++) err_q[c] <= (err_q[c] & ~clr[c]) | ev[c];
      arm_q    <= en_sum;
      reinit_q <= (rsy_mask | auto_mask) & LMASK;
      rd_data  <= rd_en ? rd_mux : '0;
      if (wr_en) begin
        case (addr)
          A_CTL:             ctl_q  <= wr_data;
          A_MISC:            misc_q <= wr_data[4:0];
          A_ODIS:            odis_q[DW-1:0] <= wr_data & LMASK[DW-1:0];
          A_ODIS + AW'(1):   odis_q[PW-1:DW] <= wr_data & LMASK[PW-1:DW];
          A_LPBK:            lpbk_q[DW-1:0] <= wr_data & LMASK[DW-1:0];
          A_LPBK + AW'(1):   lpbk_q[PW-1:DW] <= wr_data & LMASK[PW-1:DW];
          default: ;
        endcase
      end
    end
  end

  assign reinit     = reinit_q[NLINK-1:0];
  assign out_en     = ~odis_q[NLINK-1:0];
  assign loopback   = lpbk_q[NLINK-1:0];
  assign cell_delay = misc_q[3:0];
  assign bist_en    = misc_q[4];
endmodule

module xbar_err_regs_chk #(
  parameter int NLINK = 16,
  parameter int AW    = 6,
  parameter int DW    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      addr,
  input logic               wr_en,
  input logic               rd_en,
  input logic [DW-1:0]      wr_data,
  input logic [DW-1:0]      rd_data,
  input logic               irq_n,
  input logic [NLINK-1:0]   reinit,
  input logic [NLINK-1:0]   ev_link,
  input logic [2*DW-1:0]    err_link
);
  localparam int PW = 2 * DW;
  logic [PW-1:0] rpad;
  assign rpad = PW'(reinit);

  assert_resync_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == AW'(11)) |-> ((rpad[DW-1:0] & $past(wr_data)) == $past(wr_data)));

  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> (rd_data == '0));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && addr > AW'(16)) |-> (rd_data == '0));

  assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == AW'(9) && wr_data[3:0] == 4'h0) |-> irq_n);

  assert_event_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_link != '0) |-> (err_link != '0));
endmodule

bind xbar_err_regs xbar_err_regs_chk #(.NLINK(NLINK), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n), .reinit(reinit),
  .ev_link(ev_link), .err_link(err_q[3])
);

// File: tb/xbar_err_regs_tb.sv
`timescale 1ns/1ps
module xbar_err_regs_tb_top;
  logic        clk, rst_n, wr_en, rd_en, irq_n, bist_en;
  logic [5:0]  addr;
  logic [7:0]  wr_data, rd_data;
  logic [15:0] ev_cell, ev_recov, ev_thresh, ev_link, reinit, out_en, loopback;
  logic [3:0]  cell_delay;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  xbar_err_regs dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .ev_cell(ev_cell), .ev_recov(ev_recov),
    .ev_thresh(ev_thresh), .ev_link(ev_link), .irq_n(irq_n), .reinit(reinit),
    .out_en(out_en), .loopback(loopback), .cell_delay(cell_delay), .bist_en(bist_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {is_read, req, addr, data, expected}
  localparam int NV = 20;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 4'd4,  6'h09, 8'hA5, 8'h00},  // R4 enables
    {1'b1, 4'd4,  6'h09, 8'h00, 8'hA5},
    {1'b0, 4'd9,  6'h0A, 8'hFF, 8'h00},  // R9 misc
    {1'b1, 4'd9,  6'h0A, 8'h00, 8'h1F},
    {1'b0, 4'd8,  6'h0D, 8'h3C, 8'h00},  // R8 disable/loopback
    {1'b1, 4'd8,  6'h0D, 8'h00, 8'h3C},
    {1'b0, 4'd8,  6'h0E, 8'h81, 8'h00},
    {1'b1, 4'd8,  6'h0E, 8'h00, 8'h81},
    {1'b0, 4'd8,  6'h0F, 8'h12, 8'h00},
    {1'b1, 4'd8,  6'h0F, 8'h00, 8'h12},
    {1'b0, 4'd8,  6'h10, 8'h34, 8'h00},
    {1'b1, 4'd8,  6'h10, 8'h00, 8'h34},
    {1'b0, 4'd10, 6'h00, 8'hFF, 8'h00},  // R10 read-only writes
    {1'b1, 4'd10, 6'h00, 8'h00, 8'h00},
    {1'b0, 4'd10, 6'h08, 8'hFF, 8'h00},
    {1'b1, 4'd10, 6'h08, 8'h00, 8'h00},
    {1'b1, 4'd7,  6'h0B, 8'h00, 8'h00},  // R7 reads zero
    {1'b1, 4'd10, 6'h11, 8'h00, 8'h00},  // R10 unmapped
    {1'b1, 4'd10, 6'h3F, 8'h00, 8'h00},
    {1'b0, 4'd4,  6'h09, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic pulse(input int cls, input logic [15:0] v);
    @(negedge clk);
    case (cls)
      0: ev_cell = v;
      1: ev_recov = v;
      2: ev_thresh = v;
      default: ev_link = v;
    endcase
    @(negedge clk);
    ev_cell = '0; ev_recov = '0; ev_thresh = '0; ev_link = '0;
  endtask

  initial begin
    logic [7:0] d;
    int cnt;
    logic [15:0] seen;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
    ev_cell = '0; ev_recov = '0; ev_thresh = '0; ev_link = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 irq_n", 16'(irq_n), 16'h1);
    chk("R11 reinit", reinit, 16'h0);
    chk("R11 out_en", out_en, 16'hFFFF);
    chk("R11 loopback", loopback, 16'h0);
    chk("R11 rd_data", 16'(rd_data), 16'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][26]) begin
        rd(VEC[i][21:16], d);
        chk($sformatf("R%0d table %0d", VEC[i][25:22], i), 16'(d), 16'(VEC[i][7:0]));
      end else begin
        wr(VEC[i][21:16], VEC[i][15:8]);
      end
    end
    chk("R8 out_en", out_en, 16'h7EC3);
    chk("R8 loopback", loopback, 16'h3412);
    chk("R9 cell_delay", 16'(cell_delay), 16'hF);
    chk("R9 bist_en", 16'(bist_en), 16'h1);

    // R1, R2, R5: link class
    pulse(3, 16'h0102);
    rd(6'h08, d); chk("R5 status link", 16'(d), 16'h01);
    rd(6'h06, d); chk("R1 link lsb", 16'(d), 16'h02);
    rd(6'h06, d); chk("R2 lsb cleared", 16'(d), 16'h00);
    rd(6'h07, d); chk("R2 msb kept", 16'(d), 16'h01);
    rd(6'h08, d); chk("R5 status empty", 16'(d), 16'h00);

    // R4 masking and summary
    wr(6'h09, 8'h04);
    pulse(2, 16'h0002);
    chk("R4 masked class", 16'(irq_n), 16'h1);
    rd(6'h08, d); chk("R5 status thresh", 16'(d), 16'h02);
    pulse(1, 16'h0020);
    chk("R4 irq asserted", 16'(irq_n), 16'h0);
    rd(6'h02, d); chk("R1 recov lsb", 16'(d), 16'h20);
    chk("R4 irq released", 16'(irq_n), 16'h1);
    rd(6'h04, d); chk("R1 thresh lsb", 16'(d), 16'h02);
    wr(6'h09, 8'h00);

    // R3 event during clearing read
    pulse(0, 16'h0001);
    @(negedge clk); addr = 6'h00; rd_en = 1'b1; ev_cell = 16'h0001;
    @(negedge clk); rd_en = 1'b0; ev_cell = '0; d = rd_data;
    chk("R3 read value", 16'(d), 16'h01);
    rd(6'h00, d); chk("R3 event kept", 16'(d), 16'h01);
    rd(6'h00, d); chk("R2 cleared after", 16'(d), 16'h00);

    // R6 automatic relink on link class
    wr(6'h09, 8'h10);
    pulse(3, 16'h0008);
    cnt = 0; seen = '0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (reinit != '0) begin cnt++; seen = reinit; end
    end
    chk("R6 one pulse", 16'(cnt), 16'h1);
    chk("R6 pulse links", seen, 16'h0008);
    pulse(3, 16'h0010);
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (reinit != '0) cnt++;
    end
    chk("R6 no repeat", 16'(cnt), 16'h0);
    rd(6'h06, d); chk("R6 accumulated", 16'(d), 16'h18);
    wr(6'h09, 8'h00);

    // R7 resync pulses
    wr(6'h0B, 8'h81);
    chk("R7 resync lsb", reinit, 16'h0081);
    @(negedge clk); chk("R7 self clear", reinit, 16'h0000);
    wr(6'h0C, 8'h40);
    chk("R7 resync msb", reinit, 16'h4000);

    // R11 reset after configuration
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R11 out_en after", out_en, 16'hFFFF);
    chk("R11 loopback after", loopback, 16'h0);
    rd(6'h0A, d); chk("R11 misc cleared", 16'(d), 16'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1..all: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule